// File: doc/BRIEF.md
# Multicycle Instruction Sequencer

This block is the control unit of a processor core that runs each instruction over several short clock cycles. Every instruction first goes through a fetch step and then a decode step. After that it takes its own path for its class: register-to-register arithmetic, load, store, branch-if-equal or jump. A completion step ends the path and control returns to fetch.

The only input the sequencer reads is the opcode held in the instruction register. It drives every enable, strobe and multiplexer select of the shared datapath.

The machine is a Moore machine: all outputs depend only on the registered state. During decode the datapath adds the shifted immediate to the already incremented program counter and holds the sum in a target register. The branch step therefore only subtracts the two operands and, if they are equal, loads the program counter from that register.

Top module: `mcf_ctrl`

## Requirements
- R1: A synchronous reset, whether held from power-up or asserted in the middle of any instruction, puts the sequencer in fetch on the following cycle.
- R2: Fetch asserts mem_rd, ir_ld and pc_wr, with mem_addr_sel=0, alu_a_sel=0, alu_b_sel=01, alu_op=00 and pc_src=00. Decode always follows fetch.
- R3: Decode asserts tgt_ld with alu_a_sel=0, alu_b_sel=11 and alu_op=00. It dispatches on the opcode as follows:
  - 000000 (register arithmetic) goes to execute.
  - 100011 (load) and 101011 (store) go to address computation.
  - 000100 (branch-if-equal) goes to branch completion.
  - 000010 (jump) goes to jump completion.
- R4: Address computation drives alu_a_sel=1, alu_b_sel=10 and alu_op=00. It moves to memory read for a load and to memory write for a store.
- R5: Execute drives alu_a_sel=1, alu_b_sel=00 and alu_op=10, then moves to arithmetic completion. Arithmetic completion asserts rf_wr with wr_dst_rd=1 and wb_from_mem=0.
- R6: Memory read asserts mem_rd and memory write asserts mem_wr, both with mem_addr_sel=1. Memory read is followed by write-back, which asserts rf_wr with wb_from_mem=1 and wr_dst_rd=0.
- R7: Branch completion drives alu_a_sel=1, alu_b_sel=00, alu_op=01 (subtract) and pc_src=01, and asserts pc_wr_cond.
- R8: Jump completion asserts pc_wr with pc_src=10.
- R9: Every enable and strobe that a state does not list is 0. Memory write, arithmetic completion, write-back, branch completion and jump completion each return to fetch on the next clock. A load therefore takes 5 cycles, a store or arithmetic instruction 4, and a branch or jump 3.
- R10: An opcode outside the five listed in R3 makes decode return straight to fetch. No strobe other than decode's own tgt_ld is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | OPC_W | Opcode field of the instruction register |
| pc_wr | output | 1 | Unconditional program counter load |
| pc_wr_cond | output | 1 | Program counter load if the ALU result is zero |
| mem_addr_sel | output | 1 | Memory address source: 0 program counter, 1 ALU output |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| ir_ld | output | 1 | Instruction register load |
| wb_from_mem | output | 1 | Register write data source: 1 memory data, 0 ALU output |
| wr_dst_rd | output | 1 | Destination register field: 1 rd, 0 rt |
| rf_wr | output | 1 | Register file write enable |
| tgt_ld | output | 1 | Branch target register load |
| alu_a_sel | output | 1 | ALU operand A: 0 program counter, 1 register A |
| alu_b_sel | output | 2 | ALU operand B: 00 register B, 01 constant 4, 10 immediate, 11 shifted immediate |
| alu_op | output | 2 | ALU operation class: 00 add, 01 subtract, 10 function field |
| pc_src | output | 2 | Program counter source: 00 ALU, 01 target register, 10 jump address |

## Verification
The hardest cases to reach from the ports are the ones the opcode only influences during decode and address computation. These are an unknown opcode leaving decode, and a reset that lands in the middle of an instruction path rather than at fetch.

The stimulus changes the opcode only while the sequencer is in fetch, as an instruction register would. It first runs directed sequences for every class, for an illegal opcode and for a reset inside a branch. It then runs a long $urandom stream with a fixed seed, in which about one opcode in five is illegal and resets are sprinkled at random points. Each cycle is compared with a state model in the bench.

// File: rtl/mcf_pkg.sv
package mcf_pkg;

   localparam int NUM_STATES = 10;
   localparam int STATE_W    = $clog2(NUM_STATES);
   localparam int SEL_W      = 2;

   typedef enum logic [STATE_W-1:0] {
      ST_FETCH  = 4'd0,
      ST_DECODE = 4'd1,
      ST_ADDR   = 4'd2,
      ST_EXEC   = 4'd3,
      ST_RDONE  = 4'd4,
      ST_MEMRD  = 4'd5,
      ST_MEMWR  = 4'd6,
      ST_WBACK  = 4'd7,
      ST_BRANCH = 4'd8,
      ST_JUMP   = 4'd9
   } mcf_state_e;

   typedef enum logic [2:0] {
      CL_NONE, CL_ARITH, CL_LOAD, CL_STORE, CL_BEQ, CL_JMP
   } mcf_class_e;

   typedef struct packed {
      logic             pc_wr;
      logic             pc_wr_cond;
      logic             mem_addr_sel;
      logic             mem_rd;
      logic             mem_wr;
      logic             ir_ld;
      logic             wb_from_mem;
      logic             wr_dst_rd;
      logic             rf_wr;
      logic             tgt_ld;
      logic             alu_a_sel;
      logic [SEL_W-1:0] alu_b_sel;
      logic [SEL_W-1:0] alu_op;
      logic [SEL_W-1:0] pc_src;
   } mcf_ctl_t;

   // ALU operand B, ALU class and PC source codes
   localparam logic [SEL_W-1:0] B_REG  = 2'b00;
   localparam logic [SEL_W-1:0] B_FOUR = 2'b01;
   localparam logic [SEL_W-1:0] B_IMM  = 2'b10;
   localparam logic [SEL_W-1:0] B_SIMM = 2'b11;
   localparam logic [SEL_W-1:0] OP_ADD = 2'b00;
   localparam logic [SEL_W-1:0] OP_SUB = 2'b01;
   localparam logic [SEL_W-1:0] OP_FN  = 2'b10;
   localparam logic [SEL_W-1:0] PC_ALU = 2'b00;
   localparam logic [SEL_W-1:0] PC_TGT = 2'b01;
   localparam logic [SEL_W-1:0] PC_JMP = 2'b10;

endpackage

// File: rtl/mcf_opc_class.sv
module mcf_opc_class
   import mcf_pkg::*;
#(
   parameter int               OPC_W     = 6,
   parameter logic [OPC_W-1:0] OPC_ARITH = 6'b000000,
   parameter logic [OPC_W-1:0] OPC_LOAD  = 6'b100011,
   parameter logic [OPC_W-1:0] OPC_STORE = 6'b101011,
   parameter logic [OPC_W-1:0] OPC_BEQ   = 6'b000100,
   parameter logic [OPC_W-1:0] OPC_JMP   = 6'b000010
) (
   input  logic [OPC_W-1:0] opcode,
   output mcf_class_e       cls
);

   always_comb begin
      cls = CL_NONE;
      if      (opcode == OPC_ARITH) cls = CL_ARITH;
      else if (opcode == OPC_LOAD)  cls = CL_LOAD;
      else if (opcode == OPC_STORE) cls = CL_STORE;
      else if (opcode == OPC_BEQ)   cls = CL_BEQ;
      else if (opcode == OPC_JMP)   cls = CL_JMP;
   end

endmodule

// File: rtl/mcf_next.sv
module mcf_next
   import mcf_pkg::*;
(
   input  mcf_state_e cur,
   input  mcf_class_e cls,
   output mcf_state_e nxt
);

   always_comb begin
      nxt = ST_FETCH;
      unique case (cur)
         ST_FETCH:  nxt = ST_DECODE;
         ST_DECODE: begin
            unique case (cls)
               CL_ARITH:          nxt = ST_EXEC;
               CL_LOAD, CL_STORE: nxt = ST_ADDR;
               CL_BEQ:            nxt = ST_BRANCH;
               CL_JMP:            nxt = ST_JUMP;
               default:           nxt = ST_FETCH;
            endcase
         end
         ST_ADDR: begin
            if      (cls == CL_LOAD)  nxt = ST_MEMRD;
            else if (cls == CL_STORE) nxt = ST_MEMWR;
            else                      nxt = ST_FETCH;
         end
         ST_EXEC:  nxt = ST_RDONE;
         ST_MEMRD: nxt = ST_WBACK;
         default:  nxt = ST_FETCH;
      endcase
   end

endmodule

// File: rtl/mcf_state_reg.sv
module mcf_state_reg
   import mcf_pkg::*;
#(
   parameter bit ONE_HOT = 1'b0
) (
   input  logic       clk,
   input  logic       rst,
   input  mcf_state_e nxt,
   output mcf_state_e cur
);

   generate
      if (ONE_HOT) begin : g_onehot
         logic [NUM_STATES-1:0] oh_q;
         always_ff @(posedge clk) begin
            if (rst) oh_q <= NUM_STATES'(1) << ST_FETCH;
            else     oh_q <= NUM_STATES'(1) << nxt;
         end
         always_comb begin
            cur = ST_FETCH;
            for (int i = 0; i < NUM_STATES; i++)
               if (oh_q[i]) cur = mcf_state_e'(i[STATE_W-1:0]);
         end
      end else begin : g_binary
         mcf_state_e st_q;
         always_ff @(posedge clk) begin
            if (rst) st_q <= ST_FETCH;
            else     st_q <= nxt;
         end
         assign cur = st_q;
      end
   endgenerate

endmodule

// File: rtl/mcf_outputs.sv
module mcf_outputs
   import mcf_pkg::*;
(
   input  mcf_state_e cur,
   output mcf_ctl_t   ctl
);

   // Selects not named for a state are held at 0 (free choice).
   always_comb begin
      ctl = '0;
      unique case (cur)
         ST_FETCH: begin
            ctl.mem_rd    = 1'b1;
            ctl.ir_ld     = 1'b1;
            ctl.pc_wr     = 1'b1;
            ctl.alu_b_sel = B_FOUR;
            ctl.alu_op    = OP_ADD;
            ctl.pc_src    = PC_ALU;
         end
         ST_DECODE: begin
            ctl.tgt_ld    = 1'b1;
            ctl.alu_b_sel = B_SIMM;
            ctl.alu_op    = OP_ADD;
         end
         ST_ADDR: begin
            ctl.alu_a_sel = 1'b1;
            ctl.alu_b_sel = B_IMM;
            ctl.alu_op    = OP_ADD;
         end
         ST_EXEC: begin
            ctl.alu_a_sel = 1'b1;
            ctl.alu_b_sel = B_REG;
            ctl.alu_op    = OP_FN;
         end
         ST_RDONE: begin
            ctl.rf_wr     = 1'b1;
            ctl.wr_dst_rd = 1'b1;
         end
         ST_MEMRD: begin
            ctl.mem_rd       = 1'b1;
            ctl.mem_addr_sel = 1'b1;
            ctl.alu_a_sel    = 1'b1;
            ctl.alu_b_sel    = B_IMM;
         end
         ST_MEMWR: begin
            ctl.mem_wr       = 1'b1;
            ctl.mem_addr_sel = 1'b1;
            ctl.alu_a_sel    = 1'b1;
            ctl.alu_b_sel    = B_IMM;
         end
         ST_WBACK: begin
            ctl.rf_wr       = 1'b1;
            ctl.wb_from_mem = 1'b1;
         end
         ST_BRANCH: begin
            ctl.pc_wr_cond = 1'b1;
            ctl.alu_a_sel  = 1'b1;
            ctl.alu_b_sel  = B_REG;
            ctl.alu_op     = OP_SUB;
            ctl.pc_src     = PC_TGT;
         end
         ST_JUMP: begin
            ctl.pc_wr  = 1'b1;
            ctl.pc_src = PC_JMP;
         end
         default: ctl = '0;
      endcase
   end

endmodule

// File: rtl/mcf_ctrl.sv
module mcf_ctrl
   import mcf_pkg::*;
#(
   parameter int               OPC_W     = 6,
   parameter logic [OPC_W-1:0] OPC_ARITH = 6'b000000,
   parameter logic [OPC_W-1:0] OPC_LOAD  = 6'b100011,
   parameter logic [OPC_W-1:0] OPC_STORE = 6'b101011,
   parameter logic [OPC_W-1:0] OPC_BEQ   = 6'b000100,
   parameter logic [OPC_W-1:0] OPC_JMP   = 6'b000010,
   parameter bit               ONE_HOT   = 1'b0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [OPC_W-1:0] opcode,
   output logic             pc_wr,
   output logic             pc_wr_cond,
   output logic             mem_addr_sel,
   output logic             mem_rd,
   output logic             mem_wr,
   output logic             ir_ld,
   output logic             wb_from_mem,
   output logic             wr_dst_rd,
   output logic             rf_wr,
   output logic             tgt_ld,
   output logic             alu_a_sel,
   output logic [1:0]       alu_b_sel,
   output logic [1:0]       alu_op,
   output logic [1:0]       pc_src
);

   // elaboration-time parameter checks
   if (OPC_W < 1) begin : g_bad_width
      $error("mcf_ctrl: OPC_W must be at least 1");
   end
   if (OPC_ARITH == OPC_LOAD || OPC_ARITH == OPC_STORE || OPC_ARITH == OPC_BEQ ||
       OPC_ARITH == OPC_JMP  || OPC_LOAD  == OPC_STORE || OPC_LOAD  == OPC_BEQ ||
       OPC_LOAD  == OPC_JMP  || OPC_STORE == OPC_BEQ   || OPC_STORE == OPC_JMP ||
       OPC_BEQ   == OPC_JMP) begin : g_bad_opc
      $error("mcf_ctrl: opcode parameters must be distinct");
   end

   mcf_class_e cls;
   mcf_state_e cur_st;
   mcf_state_e nxt_st;
   mcf_ctl_t   ctl;

   mcf_opc_class #(
      .OPC_W(OPC_W), .OPC_ARITH(OPC_ARITH), .OPC_LOAD(OPC_LOAD),
      .OPC_STORE(OPC_STORE), .OPC_BEQ(OPC_BEQ), .OPC_JMP(OPC_JMP)
   ) u_cls (
      .opcode (opcode),
      .cls    (cls)
   );

   mcf_next u_next (
      .cur (cur_st),
      .cls (cls),
      .nxt (nxt_st)
   );

   mcf_state_reg #(.ONE_HOT(ONE_HOT)) u_sreg (
      .clk (clk),
      .rst (rst),
      .nxt (nxt_st),
      .cur (cur_st)
   );

   mcf_outputs u_out (
      .cur (cur_st),
      .ctl (ctl)
   );

   assign pc_wr        = ctl.pc_wr;
   assign pc_wr_cond   = ctl.pc_wr_cond;
   assign mem_addr_sel = ctl.mem_addr_sel;
   assign mem_rd       = ctl.mem_rd;
   assign mem_wr       = ctl.mem_wr;
   assign ir_ld        = ctl.ir_ld;
   assign wb_from_mem  = ctl.wb_from_mem;
   assign wr_dst_rd    = ctl.wr_dst_rd;
   assign rf_wr        = ctl.rf_wr;
   assign tgt_ld       = ctl.tgt_ld;
   assign alu_a_sel    = ctl.alu_a_sel;
   assign alu_b_sel    = ctl.alu_b_sel;
   assign alu_op       = ctl.alu_op;
   assign pc_src       = ctl.pc_src;

endmodule

// File: rtl/mcf_ctrl_chk.sv
module mcf_ctrl_chk (
   input logic       clk,
   input logic       rst,
   input logic       pc_wr,
   input logic       pc_wr_cond,
   input logic       mem_addr_sel,
   input logic       mem_rd,
   input logic       mem_wr,
   input logic       ir_ld,
   input logic       wb_from_mem,
   input logic       wr_dst_rd,
   input logic       rf_wr,
   input logic       tgt_ld,
   input logic [1:0] pc_src
);

   logic rst_q = 1'b0;
   always_ff @(posedge clk) begin
      rst_q <= rst;
      // R1: one cycle after reset is sampled the sequencer sits in fetch
      if (rst_q) begin
         a_r1_reset_to_fetch: assert (ir_ld && mem_rd && pc_wr)
            else $error("R1: not in fetch after reset");
      end
   end

   a_r2_fetch_then_decode: assert property (@(posedge clk) disable iff (rst)
      ir_ld |=> tgt_ld);

   a_r6_load_writeback: assert property (@(posedge clk) disable iff (rst)
      (mem_rd && mem_addr_sel) |=> (rf_wr && wb_from_mem && !wr_dst_rd));

   a_r5_arith_done_to_fetch: assert property (@(posedge clk) disable iff (rst)
      (rf_wr && wr_dst_rd) |=> ir_ld);

   a_r7_branch_to_fetch: assert property (@(posedge clk) disable iff (rst)
      pc_wr_cond |=> ir_ld);

   a_r8_jump_to_fetch: assert property (@(posedge clk) disable iff (rst)
      (pc_wr && pc_src == 2'b10) |=> ir_ld);

   a_r9_one_mem_strobe: assert property (@(posedge clk) disable iff (rst)
      $countones({mem_rd, mem_wr}) <= 1);

   a_r9_one_pc_load: assert property (@(posedge clk) disable iff (rst)
      $onehot0({pc_wr, pc_wr_cond}));

endmodule

bind mcf_ctrl mcf_ctrl_chk u_chk (
   .clk(clk), .rst(rst), .pc_wr(pc_wr), .pc_wr_cond(pc_wr_cond),
   .mem_addr_sel(mem_addr_sel), .mem_rd(mem_rd), .mem_wr(mem_wr),
   .ir_ld(ir_ld), .wb_from_mem(wb_from_mem), .wr_dst_rd(wr_dst_rd),
   .rf_wr(rf_wr), .tgt_ld(tgt_ld), .pc_src(pc_src)
);

// File: tb/sim_mcf_ctrl.sv
module sim_mcf_ctrl;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [5:0] opcode = 6'd0;
   logic pc_wr, pc_wr_cond, mem_addr_sel, mem_rd, mem_wr, ir_ld;
   logic wb_from_mem, wr_dst_rd, rf_wr, tgt_ld, alu_a_sel;
   logic [1:0] alu_b_sel, alu_op, pc_src;

   always #5 clk = ~clk;

   mcf_ctrl u0 (
      .clk(clk), .rst(rst), .opcode(opcode), .pc_wr(pc_wr), .pc_wr_cond(pc_wr_cond),
      .mem_addr_sel(mem_addr_sel), .mem_rd(mem_rd), .mem_wr(mem_wr), .ir_ld(ir_ld),
      .wb_from_mem(wb_from_mem), .wr_dst_rd(wr_dst_rd), .rf_wr(rf_wr), .tgt_ld(tgt_ld),
      .alu_a_sel(alu_a_sel), .alu_b_sel(alu_b_sel), .alu_op(alu_op), .pc_src(pc_src)
   );

   localparam logic [5:0] O_AR = 6'b000000, O_LD = 6'b100011, O_ST = 6'b101011,
                          O_BQ = 6'b000100, O_JM = 6'b000010;
   // model states
   localparam int M_F = 0, M_D = 1, M_A = 2, M_X = 3, M_RC = 4,
                  M_MR = 5, M_MW = 6, M_WB = 7, M_BR = 8, M_JP = 9;

   int checks = 0;
   int fails  = 0;
   int exp_st = M_F;
   string ctx = "R1";

   function automatic int b_next(int s, logic [5:0] op);
      case (s)
         M_F: return M_D;
         M_D: begin
            if (op == O_AR) return M_X;
            if (op == O_LD || op == O_ST) return M_A;
            if (op == O_BQ) return M_BR;
            if (op == O_JM) return M_JP;
            return M_F;
         end
         M_A:  return (op == O_LD) ? M_MR : M_MW;
         M_X:  return M_RC;
         M_MR: return M_WB;
         default: return M_F;
      endcase
   endfunction

   // vector: {pc_wr,pc_wr_cond,addr,mem_rd,mem_wr,ir_ld,wbmem,dst,rf_wr,tgt,a,b[2],op[2],src[2]}
   function automatic void b_expect(int s, output logic [16:0] v, output logic [16:0] m);
      m = 17'b1_1_0_1_1_1_0_0_1_1_0_00_00_00;
      v = '0;
      case (s)
         M_F:  begin v = 17'b1_0_0_1_0_1_0_0_0_0_0_01_00_00; m |= 17'b0_0_1_0_0_0_0_0_0_0_1_11_11_11; end
         M_D:  begin v = 17'b0_0_0_0_0_0_0_0_0_1_0_11_00_00; m |= 17'b0_0_0_0_0_0_0_0_0_0_1_11_11_00; end
         M_A:  begin v = 17'b0_0_0_0_0_0_0_0_0_0_1_10_00_00; m |= 17'b0_0_0_0_0_0_0_0_0_0_1_11_11_00; end
         M_X:  begin v = 17'b0_0_0_0_0_0_0_0_0_0_1_00_10_00; m |= 17'b0_0_0_0_0_0_0_0_0_0_1_11_11_00; end
         M_RC: begin v = 17'b0_0_0_0_0_0_0_1_1_0_0_00_00_00; m |= 17'b0_0_0_0_0_0_1_1_0_0_0_00_00_00; end
         M_MR: begin v = 17'b0_0_1_1_0_0_0_0_0_0_0_00_00_00; m |= 17'b0_0_1_0_0_0_0_0_0_0_0_00_00_00; end
         M_MW: begin v = 17'b0_0_1_0_1_0_0_0_0_0_0_00_00_00; m |= 17'b0_0_1_0_0_0_0_0_0_0_0_00_00_00; end
         M_WB: begin v = 17'b0_0_0_0_0_0_1_0_1_0_0_00_00_00; m |= 17'b0_0_0_0_0_0_1_1_0_0_0_00_00_00; end
         M_BR: begin v = 17'b0_1_0_0_0_0_0_0_0_0_1_00_01_01; m |= 17'b0_0_0_0_0_0_0_0_0_0_1_11_11_11; end
         default: begin v = 17'b1_0_0_0_0_0_0_0_0_0_0_00_00_10; m |= 17'b0_0_0_0_0_0_0_0_0_0_0_00_00_11; end
      endcase
   endfunction

   function automatic string b_tag(int s);
      case (s)
         M_D: return "R3";
         M_A: return "R4";
         M_X, M_RC: return "R5";
         M_MR, M_MW, M_WB: return "R6";
         M_BR: return "R7";
         M_JP: return "R8";
         default: return "R2";
      endcase
   endfunction

   // one cycle: check outputs against the model, then advance it across the edge
   task automatic step(input logic [5:0] op, input logic do_rst);
      logic [16:0] v, m, act;
      int prev;
      @(negedge clk);
      act = {pc_wr, pc_wr_cond, mem_addr_sel, mem_rd, mem_wr, ir_ld, wb_from_mem,
             wr_dst_rd, rf_wr, tgt_ld, alu_a_sel, alu_b_sel, alu_op, pc_src};
      b_expect(exp_st, v, m);
      checks++;
      if ((act & m) !== (v & m)) begin
         fails++;
         $display("FAIL %s,%s state %0d: actual %b expected %b (mask %b)",
                  b_tag(exp_st), ctx, exp_st, act & m, v & m, m);
      end
      if (exp_st == M_F) opcode = op;
      rst = do_rst;
      prev = exp_st;
      @(posedge clk);
      #1;
      if (do_rst) begin
         exp_st = M_F; ctx = "R1";
      end else begin
         exp_st = b_next(prev, opcode);
         if (exp_st == M_F && prev == M_D) ctx = "R10";
         else if (exp_st == M_F) ctx = "R9";
         else ctx = "R9";
      end
   endtask

   task automatic run_instr(input logic [5:0] op);
      step(op, 1'b0);
      while (exp_st != M_F) step(op, 1'b0);
   endtask

   initial begin
      #2_000_000;
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      logic [5:0] pool [5];
      pool = '{O_AR, O_LD, O_ST, O_BQ, O_JM};
      void'($urandom(32'd2029));
      // R1: reset held from power-up
      repeat (3) @(posedge clk);
      #1;
      exp_st = M_F;
      // directed: every class, R3 dispatch through R8
      run_instr(O_LD);
      run_instr(O_ST);
      run_instr(O_AR);
      run_instr(O_BQ);
      run_instr(O_JM);
      // R10: illegal opcode
      run_instr(6'b111111);
      run_instr(6'b000011);
      // R1: reset in the middle of a branch and of a load
      step(O_BQ, 1'b0);
      step(O_BQ, 1'b1);
      step(O_LD, 1'b0);
      step(O_LD, 1'b0);
      step(O_LD, 1'b1);
      // random mix
      for (int i = 0; i < 3000; i++) begin
         logic [5:0] op;
         if ($urandom_range(0, 4) == 0) begin
            op = 6'($urandom);
            if (op == O_AR || op == O_LD || op == O_ST || op == O_BQ || op == O_JM)
               op = 6'b110011;
         end else begin
            op = pool[$urandom_range(0, 4)];
         end
         step(op, ($urandom_range(0, 63) == 0));
      end
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule